// File: doc/BRIEF.md
# Integer Matrix-Tile Multiply-Accumulate Engine

This block updates an accumulator tile C (M_tile rows by N_tile columns) with the product of an input tile A (M_tile by K) and the transpose of an input tile B (N_tile by K). Each output element gets the dot product of row m of A and row n of B added to it. The input tiles live in small local register arrays. These arrays are laid out like groups of vector registers, VLEN bits per register. Input elements may be packed at the full accumulator width SEW, at half of it or at a quarter of it. The widening factor W is then 1, 2 or 4. Two independent flags set whether the A elements and the B elements are read as signed or as unsigned.

Software loads A, B and C through a word-wide array port. It then sets the configuration and pulses start. Configuration is the log2 of λ, W and LMUL, the vector length VL, and the two signedness flags. The engine walks every output element of the active columns. For each element it spends one cycle per register of the group. When the last element has been written back, it raises done for one cycle. The result is then read back through the same array port. The shape follows the vector configuration: M_tile = VLEN/(SEW·λ), K = λ·W·LMUL and N_tile = VL/(λ·LMUL).

Top module: `imm_tile_mac`

## Requirements
- R1: After reset, busy_o and done_o are low and every word of the A, B and C arrays reads as zero.
- R2: A started operation replaces C[m,n] with C[m,n] + Σ_k A[m,k]·B[n,k] for every row m < M_tile = VLEN/(SEW·2^lam_log) and every active column n. A's element k of row m sits in word r·(VLEN/SEW) + m·λ + j of the A array, and B's of row n in word r·(VLEN/SEW) + n·λ + j of the B array. C[m,n] is word m·M_tile + n of the C array.
- R3: Elements are EW = SEW/W bits wide with W = 2^w_log (w_log 0, 1, 2; 3 acts as 2). Sub-element s occupies bits [s·EW+EW−1 : s·EW] of its word, so the lower-indexed element is in the lower bits. Its index is k = r·λ·W + j·W + s.
- R4: cfg_a_signed_i and cfg_b_signed_i act independently. A set flag sign-extends that operand's elements to SEW before the multiply, and a clear flag zero-extends them.
- R5: Products and sums are kept modulo 2^SEW. Overflow wraps silently.
- R6: The number of active columns is N_tile = VL >> (lam_log + lmul_log), limited to M_tile. Columns n ≥ N_tile of C are left unchanged, and all M_tile rows are processed.
- R7: With LMUL = 2^lmul_log > 1, the result equals LMUL successive single-register steps applied over registers 0, 1, … in increasing order.
- R8: When start_i is sampled while idle, done_o is high for exactly one cycle, N_tile·M_tile·LMUL + 1 clock edges later. busy_o is high in between, and busy_o and done_o are never high together.
- R9: While busy_o is high, start_i and array writes are ignored.
- R10: When N_tile is 0, done_o rises on the first edge after start and C is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when idle |
| cfg_lam_log_i | input | LAM_LW | log2 of λ |
| cfg_w_log_i | input | 2 | log2 of the widening factor W |
| cfg_lmul_log_i | input | LMUL_LW | log2 of LMUL |
| cfg_vl_i | input | VL_W | Vector length in SEW words |
| cfg_a_signed_i | input | 1 | A elements are signed |
| cfg_b_signed_i | input | 1 | B elements are signed |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| arr_we_i | input | 1 | Array write enable |
| arr_sel_i | input | 2 | Array select: 0 = A, 1 = B, 2 = C |
| arr_addr_i | input | AW | Word address in the selected array |
| arr_wdata_i | input | SEW | Write data |
| arr_rdata_o | output | SEW | Read data, combinational from address |

## Verification
The host array port and the engine's write-back can both target C in the same cycle, and the host port can also hit A and B while the engine is reading them. The bench provokes this by writing an A word and a C word, and pulsing start again, a few cycles into a long LMUL=2 run. It then judges the outcome at the ports. The C array must hold exactly the value computed from the pre-run contents, the poked A word must read back unchanged, and the done pulse must still arrive at the expected cycle.

// File: rtl/imm_pkg.sv
package imm_pkg;
  typedef enum logic [1:0] {
    SEL_A = 2'd0,
    SEL_B = 2'd1,
    SEL_C = 2'd2
  } arr_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } state_e;
endpackage

// File: rtl/imm_dot.sv
// One register slice of a row-by-row dot product, modulo 2^SEW.
module imm_dot #(
  parameter int SEW    = 32,
  parameter int LAM_LW = 1,
  localparam int LAM_MAX = 1 << LAM_LW,
  localparam int SUB_MAX = 4
) (
  input  logic [SEW-1:0]    a_w_i [LAM_MAX],
  input  logic [SEW-1:0]    b_w_i [LAM_MAX],
  input  logic [LAM_LW-1:0] lam_log_i,
  input  logic [1:0]        w_log_i,
  input  logic              a_signed_i,
  input  logic              b_signed_i,
  output logic [SEW-1:0]    sum_o
);
  function automatic logic [SEW-1:0] ext(input logic [SEW-1:0] w, input int s,
                                         input logic [1:0] wl, input logic sg);
    int ew;
    logic [SEW-1:0] t;
    ew = SEW >> wl;
    if (s * ew >= SEW) return '0;
    t = (w >> (s * ew)) << (SEW - ew);
    if (sg) return $signed(t) >>> (SEW - ew);
    return t >> (SEW - ew);
  endfunction

  logic [SEW-1:0] prod [LAM_MAX][SUB_MAX];

  for (genvar j = 0; j < LAM_MAX; j++) begin : g_word
    for (genvar s = 0; s < SUB_MAX; s++) begin : g_sub
      logic en;
      assign en = (j < (1 << lam_log_i)) && (s < (1 << w_log_i));
      assign prod[j][s] = en ? ext(a_w_i[j], s, w_log_i, a_signed_i) *
                               ext(b_w_i[j], s, w_log_i, b_signed_i) : '0;
    end
  end

  always_comb begin
    sum_o = '0;
    for (int j = 0; j < LAM_MAX; j++)
      for (int s = 0; s < SUB_MAX; s++)
        sum_o = sum_o + prod[j][s];
  end
endmodule

// File: rtl/imm_seq.sv
// Walks (n outer, m middle, register r inner) and latches the configuration.
module imm_seq import imm_pkg::*; #(
  parameter int ROWS    = 8,
  parameter int LAM_LW  = 1,
  parameter int LMUL_LW = 1,
  parameter int VL_W    = 5,
  localparam int RW = $clog2(ROWS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LAM_LW-1:0]  cfg_lam_log_i,
  input  logic [1:0]         cfg_w_log_i,
  input  logic [LMUL_LW-1:0] cfg_lmul_log_i,
  input  logic [VL_W-1:0]    cfg_vl_i,
  input  logic               cfg_a_signed_i,
  input  logic               cfg_b_signed_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               first_o,
  output logic               wb_o,
  output logic [RW-1:0]      m_o,
  output logic [RW-1:0]      n_o,
  output logic [LMUL_LW-1:0] r_o,
  output logic [RW-1:0]      mrows_o,
  output logic [LAM_LW-1:0]  lam_log_o,
  output logic [1:0]         w_log_o,
  output logic               a_signed_o,
  output logic               b_signed_o
);
  state_e             state_q;
  logic [RW-1:0]      m_q, n_q, mrows_q, ncols_q;
  logic [LMUL_LW-1:0] r_q, lmul_q;
  logic [LAM_LW-1:0]  lam_q;
  logic [1:0]         w_q;
  logic               as_q, bs_q;
  int                 nc_i, mr_i;
  logic               last_r, last_m, last_n;

  always_comb begin
    mr_i = ROWS >> cfg_lam_log_i;
    nc_i = int'(cfg_vl_i) >> (int'(cfg_lam_log_i) + int'(cfg_lmul_log_i));
    if (nc_i > mr_i) nc_i = mr_i;
  end

  assign last_r = (int'(r_q) == (1 << lmul_q) - 1);
  assign last_m = (m_q == mrows_q - RW'(1));
  assign last_n = (n_q == ncols_q - RW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      m_q     <= '0;
      n_q     <= '0;
      r_q     <= '0;
      mrows_q <= '0;
      ncols_q <= '0;
      lmul_q  <= '0;
      lam_q   <= '0;
      w_q     <= '0;
      as_q    <= 1'b0;
      bs_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          m_q     <= '0;
          n_q     <= '0;
          r_q     <= '0;
          mrows_q <= RW'(mr_i);
          ncols_q <= RW'(nc_i);
          lmul_q  <= cfg_lmul_log_i;
          lam_q   <= cfg_lam_log_i;
          w_q     <= (cfg_w_log_i == 2'd3) ? 2'd2 : cfg_w_log_i;
          as_q    <= cfg_a_signed_i;
          bs_q    <= cfg_b_signed_i;
          state_q <= (nc_i == 0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          if (!last_r) begin
            r_q <= r_q + LMUL_LW'(1);
          end else begin
            r_q <= '0;
            if (!last_m) begin
              m_q <= m_q + RW'(1);
            end else begin
              m_q <= '0;
              if (last_n) state_q <= ST_DONE;
              else n_q <= n_q + RW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = (state_q == ST_DONE);
  assign first_o    = (r_q == '0);
  assign wb_o       = busy_o && last_r;
  assign m_o        = m_q;
  assign n_o        = n_q;
  assign r_o        = r_q;
  assign mrows_o    = mrows_q;
  assign lam_log_o  = lam_q;
  assign w_log_o    = w_q;
  assign a_signed_o = as_q;
  assign b_signed_o = bs_q;
endmodule

// File: rtl/imm_tile_mac.sv
module imm_tile_mac import imm_pkg::*; #(
  parameter int VLEN    = 256,
  parameter int SEW     = 32,
  parameter int LAM_LW  = 1,
  parameter int LMUL_LW = 1,
  localparam int WPR      = VLEN / SEW,
  localparam int LMUL_MAX = 1 << LMUL_LW,
  localparam int AB_WORDS = WPR * LMUL_MAX,
  localparam int C_WORDS  = WPR * WPR,
  localparam int AW       = $clog2(C_WORDS),
  localparam int VL_W     = $clog2(AB_WORDS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LAM_LW-1:0]  cfg_lam_log_i,
  input  logic [1:0]         cfg_w_log_i,
  input  logic [LMUL_LW-1:0] cfg_lmul_log_i,
  input  logic [VL_W-1:0]    cfg_vl_i,
  input  logic               cfg_a_signed_i,
  input  logic               cfg_b_signed_i,
  output logic               busy_o,
  output logic               done_o,
  input  logic               arr_we_i,
  input  logic [1:0]         arr_sel_i,
  input  logic [AW-1:0]      arr_addr_i,
  input  logic [SEW-1:0]     arr_wdata_i,
  output logic [SEW-1:0]     arr_rdata_o
);
  localparam int LAM_MAX = 1 << LAM_LW;
  localparam int ABW     = $clog2(AB_WORDS);
  localparam int RW      = $clog2(WPR + 1);

  logic [SEW-1:0] a_q [AB_WORDS];
  logic [SEW-1:0] b_q [AB_WORDS];
  logic [SEW-1:0] c_q [C_WORDS];
  logic [SEW-1:0] acc_q;

  logic               first, wb;
  logic [RW-1:0]      m, n, mrows;
  logic [LMUL_LW-1:0] r;
  logic [LAM_LW-1:0]  lam_log;
  logic [1:0]         w_log;
  logic               a_sg, b_sg;

  imm_seq #(
    .ROWS(WPR), .LAM_LW(LAM_LW), .LMUL_LW(LMUL_LW), .VL_W(VL_W)
  ) i_seq (
    .clk_i, .rst_ni, .start_i,
    .cfg_lam_log_i, .cfg_w_log_i, .cfg_lmul_log_i, .cfg_vl_i,
    .cfg_a_signed_i, .cfg_b_signed_i,
    .busy_o, .done_o,
    .first_o(first), .wb_o(wb), .m_o(m), .n_o(n), .r_o(r), .mrows_o(mrows),
    .lam_log_o(lam_log), .w_log_o(w_log), .a_signed_o(a_sg), .b_signed_o(b_sg)
  );

  logic [SEW-1:0] a_w [LAM_MAX];
  logic [SEW-1:0] b_w [LAM_MAX];
  logic [AW-1:0]  c_idx;
  logic [SEW-1:0] dot, sum;

  always_comb begin
    for (int j = 0; j < LAM_MAX; j++) begin
      a_w[j] = a_q[ABW'(int'(r) * WPR + (int'(m) << lam_log) + j)];
      b_w[j] = b_q[ABW'(int'(r) * WPR + (int'(n) << lam_log) + j)];
    end
    c_idx = AW'(int'(m) * int'(mrows) + int'(n));
  end

  imm_dot #(.SEW(SEW), .LAM_LW(LAM_LW)) i_dot (
    .a_w_i(a_w), .b_w_i(b_w), .lam_log_i(lam_log), .w_log_i(w_log),
    .a_signed_i(a_sg), .b_signed_i(b_sg), .sum_o(dot)
  );

  // The first register of a group starts from C; later ones chain through acc_q.
  assign sum = (first ? c_q[c_idx] : acc_q) + dot;

  logic host_we;
  assign host_we = arr_we_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < AB_WORDS; i++) begin
        a_q[i] <= '0;
        b_q[i] <= '0;
      end
      for (int i = 0; i < C_WORDS; i++) c_q[i] <= '0;
      acc_q <= '0;
    end else begin
      if (host_we) begin
        case (arr_sel_e'(arr_sel_i))
          SEL_A:   a_q[arr_addr_i[ABW-1:0]] <= arr_wdata_i;
          SEL_B:   b_q[arr_addr_i[ABW-1:0]] <= arr_wdata_i;
          SEL_C:   c_q[arr_addr_i] <= arr_wdata_i;
          default: ;
        endcase
      end
      if (busy_o) begin
        if (wb) c_q[c_idx] <= sum;
        else    acc_q <= sum;
      end
    end
  end

  always_comb begin
    case (arr_sel_e'(arr_sel_i))
      SEL_A:   arr_rdata_o = a_q[arr_addr_i[ABW-1:0]];
      SEL_B:   arr_rdata_o = b_q[arr_addr_i[ABW-1:0]];
      SEL_C:   arr_rdata_o = c_q[arr_addr_i];
      default: arr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/imm_tile_mac_chk.sv
module imm_tile_mac_chk #(
  parameter int SEW      = 32,
  parameter int AB_WORDS = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [SEW-1:0] a_q [AB_WORDS],
  input logic [SEW-1:0] b_q [AB_WORDS]
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R8

  AST_BUSY_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R8

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o)); // R9

  AST_DONE_FOLLOWS_WORK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) || $past(start_i))); // R10

  for (genvar i = 0; i < AB_WORDS; i++) begin : g_hold
    AST_INPUTS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> ($stable(a_q[i]) && $stable(b_q[i]))); // R9
  end
endmodule

bind imm_tile_mac imm_tile_mac_chk #(.SEW(SEW), .AB_WORDS(AB_WORDS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .a_q(a_q), .b_q(b_q)
);

// File: tb/test_imm_tile_mac.sv
module test_imm_tile_mac;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [0:0]  cfg_lam_log_i = 1'b1;
  logic [1:0]  cfg_w_log_i = 2'd0;
  logic [0:0]  cfg_lmul_log_i = 1'b0;
  logic [4:0]  cfg_vl_i = '0;
  logic        cfg_a_signed_i = 1'b0;
  logic        cfg_b_signed_i = 1'b0;
  logic        busy_o, done_o;
  logic        arr_we_i = 1'b0;
  logic [1:0]  arr_sel_i = 2'd0;
  logic [5:0]  arr_addr_i = '0;
  logic [31:0] arr_wdata_i = '0;
  logic [31:0] arr_rdata_o;

  always #4 clk_i = ~clk_i;

  imm_tile_mac i_imm_tile_mac (.*);

  int n_chk = 0, n_fail = 0;
  logic [31:0] a_sh [16], b_sh [16], c_sh [16], c_ref [16];
  logic [31:0] lcg = 32'h1234_5678;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int addr, input logic [31:0] d);
    @(negedge clk_i);
    arr_we_i = 1'b1; arr_sel_i = sel; arr_addr_i = 6'(addr); arr_wdata_i = d;
    @(negedge clk_i);
    arr_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input int addr, output logic [31:0] d);
    @(negedge clk_i);
    arr_we_i = 1'b0; arr_sel_i = sel; arr_addr_i = 6'(addr);
    #1 d = arr_rdata_o;
  endtask

  task automatic load_all(input bit rnd, input logic [31:0] av, input logic [31:0] bv,
                          input logic [31:0] cv);
    for (int i = 0; i < 16; i++) begin
      if (rnd) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223; a_sh[i] = lcg;
        lcg = lcg * 32'd1664525 + 32'd1013904223; b_sh[i] = lcg;
        lcg = lcg * 32'd1664525 + 32'd1013904223; c_sh[i] = lcg;
      end else begin
        a_sh[i] = av; b_sh[i] = bv; c_sh[i] = cv;
      end
      wr(2'd0, i, a_sh[i]);
      wr(2'd1, i, b_sh[i]);
      wr(2'd2, i, c_sh[i]);
    end
  endtask

  function automatic logic [31:0] fld(input logic [31:0] w, input int s, input int wl,
                                      input bit sg);
    int ew;
    logic [31:0] mask, v;
    ew   = 32 >> wl;
    mask = (ew == 32) ? 32'hFFFF_FFFF : ((32'h1 << ew) - 32'h1);
    v    = (w >> (s * ew)) & mask;
    if (sg && v[ew-1]) v = v | ~mask;
    return v;
  endfunction

  // lambda = 2, M_tile = 4 in every scenario
  task automatic calc_ref(input int wl, input int ll, input int vl, input bit as_,
                          input bit bs_);
    int nt;
    logic [31:0] acc;
    nt = vl >> (1 + ll);
    if (nt > 4) nt = 4;
    c_ref = c_sh;
    for (int nn = 0; nn < nt; nn++)
      for (int m = 0; m < 4; m++) begin
        acc = c_sh[m*4+nn];
        for (int r = 0; r < (1 << ll); r++)
          for (int j = 0; j < 2; j++)
            for (int s = 0; s < (1 << wl); s++)
              acc = acc + fld(a_sh[r*8+m*2+j], s, wl, as_) * fld(b_sh[r*8+nn*2+j], s, wl, bs_);
        c_ref[m*4+nn] = acc;
      end
  endtask

  task automatic run_op(input int wl, input int ll, input int vl, input bit as_,
                        input bit bs_, input bit poke, input string req);
    int nt, exp_lat, cnt;
    nt = vl >> (1 + ll);
    if (nt > 4) nt = 4;
    exp_lat = nt * 4 * (1 << ll) + 1;
    calc_ref(wl, ll, vl, as_, bs_);
    @(negedge clk_i);
    cfg_lam_log_i = 1'b1; cfg_w_log_i = 2'(wl); cfg_lmul_log_i = 1'(ll);
    cfg_vl_i = 5'(vl); cfg_a_signed_i = as_; cfg_b_signed_i = bs_;
    start_i = 1'b1;
    cnt = 0;
    while (cnt < 2000) begin
      @(negedge clk_i);
      start_i = 1'b0;
      arr_we_i = 1'b0;
      cnt++;
      if (done_o) break;
      if (poke && cnt == 5) begin
        start_i = 1'b1;
        arr_we_i = 1'b1; arr_sel_i = 2'd2; arr_addr_i = 6'd5; arr_wdata_i = 32'hDEAD_0005;
      end
      if (poke && cnt == 7) begin
        arr_we_i = 1'b1; arr_sel_i = 2'd0; arr_addr_i = 6'd0; arr_wdata_i = 32'hBEEF_0000;
      end
    end
    chk("R8", {req, " done latency"}, 32'(cnt), 32'(exp_lat));
    chk("R8", {req, " done with busy low"}, {31'b0, busy_o}, 32'd0);
    @(negedge clk_i);
    chk("R8", {req, " done one cycle"}, {31'b0, done_o}, 32'd0);
  endtask

  task automatic check_c(input string req);
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      rd(2'd2, i, d);
      chk(req, $sformatf("C word %0d", i), d, c_ref[i]);
    end
    c_sh = c_ref;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1", "busy after reset", {31'b0, busy_o}, 32'd0);
    chk("R1", "done after reset", {31'b0, done_o}, 32'd0);
    rd(2'd0, 3, d);  chk("R1", "A word 3", d, 32'd0);
    rd(2'd1, 15, d); chk("R1", "B word 15", d, 32'd0);
    rd(2'd2, 63, d); chk("R1", "C word 63", d, 32'd0);
  endtask

  task automatic t_full_w1();
    load_all(1'b1, '0, '0, '0);
    run_op(0, 0, 8, 1'b1, 1'b1, 1'b0, "R2 W1");
    check_c("R2");
  endtask

  task automatic t_w2_lmul2();
    load_all(1'b1, '0, '0, '0);
    run_op(1, 1, 16, 1'b1, 1'b0, 1'b0, "R7 W2 LMUL2");
    check_c("R7");
  endtask

  task automatic t_w4_partial();
    load_all(1'b1, '0, '0, '0);
    run_op(2, 0, 4, 1'b0, 1'b1, 1'b0, "R6 W4 N2");
    check_c("R6");
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    load_all(1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    run_op(0, 1, 16, 1'b1, 1'b1, 1'b0, "R5 wrap");
    rd(2'd2, 9, d);
    chk("R5", "wrapped C[2,1]", d, 32'h8000_0003);
    check_c("R5");
  endtask

  task automatic t_order_sign();
    logic [31:0] d;
    load_all(1'b0, '0, '0, '0);
    a_sh[0] = 32'h0403_0201; wr(2'd0, 0, a_sh[0]);
    b_sh[0] = 32'h0000_0100; wr(2'd1, 0, b_sh[0]);
    run_op(2, 0, 8, 1'b0, 1'b0, 1'b0, "R3 order");
    rd(2'd2, 0, d);
    chk("R3", "lower element in low bits", d, 32'd2);
    check_c("R3");
    a_sh[0] = 32'h0000_00FF; wr(2'd0, 0, a_sh[0]);
    b_sh[0] = 32'h0000_0002; wr(2'd1, 0, b_sh[0]);
    run_op(2, 0, 8, 1'b1, 1'b0, 1'b0, "R4 signed A");
    rd(2'd2, 0, d);
    chk("R4", "signed A x unsigned B", d, 32'd0);
    run_op(2, 0, 8, 1'b0, 1'b1, 1'b0, "R4 unsigned A");
    rd(2'd2, 0, d);
    chk("R4", "unsigned A x signed B", d, 32'h0000_01FE);
  endtask

  task automatic t_busy_block();
    logic [31:0] d;
    load_all(1'b1, '0, '0, '0);
    run_op(0, 1, 16, 1'b0, 1'b0, 1'b1, "R9 poke");
    rd(2'd0, 0, d);
    chk("R9", "A word 0 write ignored", d, a_sh[0]);
    check_c("R9");
  endtask

  task automatic t_vl_zero();
    load_all(1'b1, '0, '0, '0);
    run_op(0, 0, 0, 1'b0, 1'b0, 1'b0, "R10 VL0");
    check_c("R10");
    run_op(0, 1, 3, 1'b0, 1'b0, 1'b0, "R10 VL3");
    check_c("R10");
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_full_w1();
    t_w2_lmul2();
    t_w4_partial();
    t_wrap();
    t_order_sign();
    t_busy_block();
    t_vl_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule